// File: doc/BRIEF.md
# Multi-Length Sliding Window Signature Scanner

This block scans a payload byte stream for signatures of several lengths. It takes one byte per clock and keeps the most recent bytes of the current packet in a shift window. Each time a byte enters, the window offers every substring that ends at the newest byte to an external membership filter of matching length. All lengths from `LMIN` to `LMAX` are offered in the same cycle. The filters answer in that cycle and may give false positives but never false negatives.

When one or more enabled filters report a hit, the block pauses the stream. It then sends the candidate lengths, longest first, to an external exact-match analyzer over a request/response handshake. It stops at the first candidate the analyzer confirms and reports that match: its length, the packet offset of its last byte, and the action code returned by the analyzer. If the analyzer rejects every candidate, nothing is reported and scanning resumes. In both cases the next byte is then accepted, so the window moves on by one byte.

Window lane 0 (bits 7:0 of `win_data`) holds the newest byte, and lane k holds the byte k positions older. A candidate of length L is lanes 0 to L-1.

Top module: `sig_window_scanner`

## Requirements
- R1: With no enabled filter hit, `in_ready` stays high and one byte is accepted on every clock where `in_valid` is high. An accepted byte appears in lane 0 on the next cycle, and lane k then holds the byte accepted k transfers earlier in the same packet.
- R2: `qry_en[i]` (length `LMIN+i`) is high only in the first cycle after a byte is accepted. It is high for exactly those lengths that do not exceed the number of bytes of the current packet held in the window (at most `LMAX`).
- R3: A `flt_hit[i]` whose `qry_en[i]` is low has no effect. If any enabled hit is present, `in_ready` is low in that same cycle and probing starts.
- R4: From the first request until probing ends, `in_ready` stays low and `win_data` stays unchanged.
- R5: Candidates are requested in strictly decreasing length, with `ana_len` equal to the candidate length. `ana_req_valid` and `ana_len` stay steady until `ana_req_ready` is seen.
- R6: A response with `ana_rsp_hit=1` ends probing. One cycle later, `match_valid` pulses for one cycle with `match_len`, `match_end` (the 0-based offset of the newest byte within its packet) and `match_act` (the action code 0 forward, 1 drop, 2 log, copied from `ana_rsp_act`).
- R7: If every candidate is rejected, `match_valid` stays low and `in_ready` is high again in the cycle after the last response.
- R8: After a byte with `in_last=1`, the next accepted byte starts a new packet. It lands at offset 0, the older lanes read zero, and no substring reaching into the previous packet is ever queried.
- R9: During and right after reset, `in_ready` is 1 and `qry_en`, `ana_req_valid`, `match_valid` and `win_data` are all 0.
- R10: `ana_rsp_valid` is ignored unless a request has been accepted and is awaiting its answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Block accepts the byte this cycle |
| win_data | output | LMAX*8 | Window, lane 0 newest |
| qry_en | output | LMAX-LMIN+1 | Per-length query enable, bit i is length LMIN+i |
| flt_hit | input | LMAX-LMIN+1 | Per-length filter result, same cycle |
| ana_req_valid | output | 1 | Candidate request to the analyzer |
| ana_req_ready | input | 1 | Analyzer takes the request |
| ana_len | output | $clog2(LMAX+1) | Candidate length |
| ana_rsp_valid | input | 1 | Analyzer answer valid |
| ana_rsp_hit | input | 1 | Candidate confirmed |
| ana_rsp_act | input | ACTW | Action code for the packet |
| match_valid | output | 1 | Confirmed match pulse |
| match_len | output | $clog2(LMAX+1) | Length of the confirmed substring |
| match_end | output | POSW | Packet offset of the substring's last byte |
| match_act | output | ACTW | Action code of the match |

## Verification
The bench targets packets shorter than `LMIN`. It also targets packet boundaries, where a design that did not flush would query substrings mixing two packets or report offsets that keep counting. Cases where every length hits at once test that probing runs from longest down to shortest and stops at the first confirmation, or, with all candidates rejected, walks every length and reports nothing. Delayed request acceptance and analyzer answers sent while the block is scanning show up as a wandering `ana_len` or as spurious matches. A back-to-back burst with no hits would expose a block that wastes a cycle per byte.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;
   typedef enum logic [1:0] {
      ST_SCAN = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } scan_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/scan_window.sv
module scan_window #(
   parameter int LMIN = 3,
   parameter int LMAX = 8,
   parameter int POSW = 16,
   localparam int FW  = $clog2(LMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [7:0]        byte_in,
   input  logic              last_in,
   output logic [LMAX*8-1:0] win_data,
   output logic [FW-1:0]     fill,
   output logic [POSW-1:0]   pos
);
   localparam logic [FW-1:0] FILL_MAX = FW'(LMAX);

   logic [7:0] lane_q [LMAX];
   logic       pkt_done_q;

   generate
      if (LMIN < 1 || LMAX < LMIN) begin : g_bad_len
         $error("scan_window: need 1 <= LMIN <= LMAX");
      end
      if (POSW < 1) begin : g_bad_pos
         $error("scan_window: POSW must be positive");
      end
   endgenerate

   // newest byte in lane 0; older lanes cleared when a new packet begins
   generate
      for (genvar k = 0; k < LMAX; k++) begin : g_lane
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n)        lane_q[k] <= '0;
               else if (shift_en) lane_q[k] <= byte_in;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n)        lane_q[k] <= '0;
               else if (shift_en) lane_q[k] <= pkt_done_q ? 8'h00 : lane_q[k-1];
            end
         end
         assign win_data[k*8 +: 8] = lane_q[k];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill       <= '0;
         pos        <= '0;
         pkt_done_q <= 1'b1;
      end else if (shift_en) begin
         pkt_done_q <= last_in;
         if (pkt_done_q) begin
            fill <= FW'(1);
            pos  <= '0;
         end else begin
            fill <= (fill == FILL_MAX) ? fill : fill + FW'(1);
            pos  <= pos + POSW'(1);
         end
      end
   end

   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(win_data)) else $error("window moved without a transfer"); // R4
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_MAX) else $error("fill above window depth"); // R2
   AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && pkt_done_q) |=> (pos == '0 && fill == FW'(1))) else $error("packet start not flushed"); // R8
endmodule

// File: rtl/lsf_pick.sv
module lsf_pick #(
   parameter int N  = 6,
   localparam int IW = sig_scan_pkg::idx_width(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] sel,
   output logic [N-1:0]  sel_oh
);
   generate
      if (N < 1) begin : g_bad_n
         $error("lsf_pick: N must be positive");
      end
   endgenerate

   // highest index means longest substring; later iterations override
   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) sel = IW'(i);
      end
   end

   assign any = |req;

   generate
      for (genvar i = 0; i < N; i++) begin : g_oh
         assign sel_oh[i] = any && (sel == IW'(i));
      end
   endgenerate

   AST_PICK_ONEHOT: assert final (!any || ($onehot(sel_oh) && (sel_oh & ~req) == '0)); // R5
endmodule

// File: rtl/probe_ctrl.sv
module probe_ctrl
   import sig_scan_pkg::*;
#(
   parameter int LMIN = 3,
   parameter int LMAX = 8,
   parameter int POSW = 16,
   parameter int ACTW = 2,
   localparam int NL  = LMAX - LMIN + 1,
   localparam int FW  = $clog2(LMAX + 1),
   localparam int IW  = idx_width(NL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   output logic            shift_en,
   input  logic [FW-1:0]   fill,
   input  logic [POSW-1:0] pos,
   output logic [NL-1:0]   qry_en,
   input  logic [NL-1:0]   flt_hit,
   output logic            ana_req_valid,
   input  logic            ana_req_ready,
   output logic [FW-1:0]   ana_len,
   input  logic            ana_rsp_valid,
   input  logic            ana_rsp_hit,
   input  logic [ACTW-1:0] ana_rsp_act,
   output logic            match_valid,
   output logic [FW-1:0]   match_len,
   output logic [POSW-1:0] match_end,
   output logic [ACTW-1:0] match_act
);
   scan_state_e state_q;
   logic          fresh_q;
   logic [NL-1:0] pend_q;
   logic [NL-1:0] hit_en;
   logic          hit_now;
   logic          pend_any;
   logic [IW-1:0] pend_sel;
   logic [NL-1:0] pend_oh;
   logic [NL-1:0] pend_left;

   generate
      if (ACTW < 2) begin : g_bad_act
         $error("probe_ctrl: ACTW must hold three action codes");
      end
   endgenerate

   // a length is queried once, right after the byte that completes it lands
   generate
      for (genvar i = 0; i < NL; i++) begin : g_qry
         localparam logic [FW-1:0] NEED = FW'(LMIN + i);
         assign qry_en[i] = (state_q == ST_SCAN) && fresh_q && (fill >= NEED);
      end
   endgenerate

   assign hit_en   = flt_hit & qry_en;
   assign hit_now  = |hit_en;
   assign in_ready = (state_q == ST_SCAN) && !hit_now;
   assign shift_en = in_valid && in_ready;

   lsf_pick #(.N(NL)) u_pick (
      .req    (pend_q),
      .any    (pend_any),
      .sel    (pend_sel),
      .sel_oh (pend_oh)
   );

   assign pend_left     = pend_q & ~pend_oh;
   assign ana_req_valid = (state_q == ST_REQ);
   assign ana_len       = FW'(LMIN) + FW'(pend_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) fresh_q <= 1'b0;
      else        fresh_q <= shift_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SCAN;
         pend_q  <= '0;
      end else begin
         unique case (state_q)
            ST_SCAN: begin
               if (hit_now) begin
                  pend_q  <= hit_en;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (ana_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (ana_rsp_valid) begin
                  if (ana_rsp_hit) begin
                     pend_q  <= '0;
                     state_q <= ST_SCAN;
                  end else begin
                     pend_q  <= pend_left;
                     state_q <= (|pend_left) ? ST_REQ : ST_SCAN;
                  end
               end
            end
            default: begin
               pend_q  <= '0;
               state_q <= ST_SCAN;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_valid <= 1'b0;
         match_len   <= '0;
         match_end   <= '0;
         match_act   <= '0;
      end else begin
         match_valid <= 1'b0;
         if (state_q == ST_WAIT && ana_rsp_valid && ana_rsp_hit) begin
            match_valid <= 1'b1;
            match_len   <= ana_len;
            match_end   <= pos;
            match_act   <= ana_rsp_act;
         end
      end
   end

   AST_NO_READY_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_SCAN) |-> !in_ready) else $error("stream open while probing"); // R4
   AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (ana_req_valid && !ana_req_ready) |=> (ana_req_valid && $stable(ana_len))) else $error("request dropped or changed"); // R5
   AST_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ana_req_valid && $past(state_q == ST_WAIT)) |-> (ana_len < $past(ana_len))) else $error("probe order not longest first"); // R5
   AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      ana_req_valid |-> (ana_len <= fill && ana_len >= FW'(LMIN))) else $error("candidate longer than packet data"); // R2
   AST_MATCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (match_len >= FW'(LMIN) && match_len <= FW'(LMAX))) else $error("match length out of range"); // R6
   AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |=> !match_valid) else $error("match longer than one cycle"); // R6
endmodule

// File: rtl/sig_window_scanner.sv
module sig_window_scanner #(
   parameter int LMIN = 3,
   parameter int LMAX = 8,
   parameter int POSW = 16,
   parameter int ACTW = 2,
   localparam int NL  = LMAX - LMIN + 1,
   localparam int FW  = $clog2(LMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic [LMAX*8-1:0] win_data,
   output logic [NL-1:0]     qry_en,
   input  logic [NL-1:0]     flt_hit,
   output logic              ana_req_valid,
   input  logic              ana_req_ready,
   output logic [FW-1:0]     ana_len,
   input  logic              ana_rsp_valid,
   input  logic              ana_rsp_hit,
   input  logic [ACTW-1:0]   ana_rsp_act,
   output logic              match_valid,
   output logic [FW-1:0]     match_len,
   output logic [POSW-1:0]   match_end,
   output logic [ACTW-1:0]   match_act
);
   logic            shift_en;
   logic [FW-1:0]   fill;
   logic [POSW-1:0] pos;

   scan_window #(.LMIN(LMIN), .LMAX(LMAX), .POSW(POSW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .byte_in  (in_data),
      .last_in  (in_last),
      .win_data (win_data),
      .fill     (fill),
      .pos      (pos)
   );

   probe_ctrl #(.LMIN(LMIN), .LMAX(LMAX), .POSW(POSW), .ACTW(ACTW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .shift_en      (shift_en),
      .fill          (fill),
      .pos           (pos),
      .qry_en        (qry_en),
      .flt_hit       (flt_hit),
      .ana_req_valid (ana_req_valid),
      .ana_req_ready (ana_req_ready),
      .ana_len       (ana_len),
      .ana_rsp_valid (ana_rsp_valid),
      .ana_rsp_hit   (ana_rsp_hit),
      .ana_rsp_act   (ana_rsp_act),
      .match_valid   (match_valid),
      .match_len     (match_len),
      .match_end     (match_end),
      .match_act     (match_act)
   );

   AST_IDLE_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (in_ready && !ana_req_valid)) else $error("probing continued after a confirm"); // R6
endmodule

// File: tb/sig_window_scanner_test.sv
`timescale 1ns/1ps
module sig_window_scanner_test;
   localparam int LMIN = 3;
   localparam int LMAX = 8;
   localparam int NL   = LMAX - LMIN + 1;
   localparam int FW   = $clog2(LMAX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0;
   logic [7:0] in_data = '0;
   logic in_ready;
   logic [LMAX*8-1:0] win_data;
   logic [NL-1:0] qry_en, flt_hit;
   logic ana_req_valid, ana_req_ready = 1'b0;
   logic [FW-1:0] ana_len;
   logic ana_rsp_valid = 1'b0, ana_rsp_hit = 1'b0;
   logic [1:0] ana_rsp_act = '0;
   logic match_valid;
   logic [FW-1:0] match_len;
   logic [15:0] match_end;
   logic [1:0] match_act;

   int checks = 0, fails = 0;
   bit done = 0;
   int flt_mode = 0;   // 0 off, 1 hashed, 2 every length
   int conf_mode = 0;  // 0 hashed, 1 reject all, 2 accept all

   logic [LMAX*8-1:0] m_win = '0;
   int m_cnt = 0, m_pos = 0;
   bit m_done = 1;

   always #4 clk = ~clk;

   sig_window_scanner #(.LMIN(LMIN), .LMAX(LMAX)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .in_ready(in_ready), .win_data(win_data), .qry_en(qry_en), .flt_hit(flt_hit),
      .ana_req_valid(ana_req_valid), .ana_req_ready(ana_req_ready), .ana_len(ana_len),
      .ana_rsp_valid(ana_rsp_valid), .ana_rsp_hit(ana_rsp_hit), .ana_rsp_act(ana_rsp_act),
      .match_valid(match_valid), .match_len(match_len), .match_end(match_end), .match_act(match_act));

   function automatic int sub_sum(input logic [LMAX*8-1:0] w, input int len);
      int s = 0;
      for (int k = 0; k < LMAX; k++) if (k < len) s += int'(w[k*8 +: 8]);
      return s;
   endfunction

   function automatic bit filt(input int mode, input logic [LMAX*8-1:0] w, input int len);
      if (mode == 2) return 1'b1;
      if (mode == 1) return (sub_sum(w, len) % 5) == 0;
      return 1'b0;
   endfunction

   function automatic bit confirm(input logic [LMAX*8-1:0] w, input int len);
      if (conf_mode == 1) return 1'b0;
      if (conf_mode == 2) return 1'b1;
      return ((sub_sum(w, len) >> 2) & 1) == 1;
   endfunction

   always_comb begin
      for (int i = 0; i < NL; i++) flt_hit[i] = filt(flt_mode, win_data, LMIN + i);
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_push(input logic [7:0] b, input logic last);
      if (m_done) begin
         m_win = '0; m_win[7:0] = b; m_cnt = 1; m_pos = 0;
      end else begin
         m_win = {m_win[LMAX*8-9:0], b};
         m_cnt = (m_cnt < LMAX) ? m_cnt + 1 : LMAX;
         m_pos++;
      end
      m_done = last;
   endtask

   // starts and ends just after a falling edge
   task automatic feed(input logic [7:0] b, input logic last);
      logic [NL-1:0] exp_hits;
      logic [NL-1:0] exp_mask;
      bit matched = 0;
      in_valid = 1'b1; in_data = b; in_last = last;
      #1 chk(in_ready == 1'b1, "R1 ready before byte", in_ready, 1);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      model_push(b, last);
      for (int i = 0; i < NL; i++) begin
         exp_mask[i] = (LMIN + i) <= m_cnt;
         exp_hits[i] = exp_mask[i] && filt(flt_mode, m_win, LMIN + i);
      end
      #1;
      chk(win_data == m_win, "R1 window lanes", win_data, m_win);
      chk(qry_en == exp_mask, "R2 query enables", qry_en, exp_mask);
      chk(in_ready == (exp_hits == '0), "R3 ready vs enabled hits", in_ready, exp_hits == '0);
      if (exp_hits != '0) begin
         for (int L = LMAX; L >= LMIN; L--) begin
            if (exp_hits[L-LMIN] && !matched) begin
               for (int t = 0; t < 6 && !ana_req_valid; t++) @(negedge clk);
               #1;
               chk(ana_req_valid == 1'b1, "R5 request issued", ana_req_valid, 1);
               chk(ana_len == FW'(L), "R5 longest first", ana_len, L);
               chk(in_ready == 1'b0, "R4 stalled while probing", in_ready, 0);
               chk(win_data == m_win, "R4 window held", win_data, m_win);
               repeat ($urandom % 3) begin
                  @(negedge clk); #1;
                  chk(ana_req_valid && ana_len == FW'(L), "R5 request steady", ana_len, L);
               end
               ana_req_ready = 1'b1;
               @(posedge clk); @(negedge clk);
               ana_req_ready = 1'b0;
               repeat ($urandom % 3) @(negedge clk);
               ana_rsp_valid = 1'b1;
               ana_rsp_hit = confirm(m_win, L);
               ana_rsp_act = 2'(sub_sum(m_win, L) % 3);
               @(posedge clk); @(negedge clk);
               ana_rsp_valid = 1'b0;
               #1;
               if (ana_rsp_hit) begin
                  matched = 1;
                  chk(match_valid == 1'b1, "R6 match pulse", match_valid, 1);
                  chk(match_len == FW'(L), "R6 match length", match_len, L);
                  chk(match_end == 16'(m_pos), "R6 match offset", match_end, m_pos);
                  chk(match_act == 2'(sub_sum(m_win, L) % 3), "R6 match action", match_act, sub_sum(m_win, L) % 3);
               end else begin
                  chk(match_valid == 1'b0, "R7 no match on reject", match_valid, 0);
               end
            end
         end
         chk(in_ready == 1'b1, "R7 scanning resumes", in_ready, 1);
         chk(ana_req_valid == 1'b0, "R6 probing ended", ana_req_valid, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready == 1'b1 && qry_en == '0 && !ana_req_valid && !match_valid && win_data == '0,
          "R9 state in reset", {in_ready, qry_en, ana_req_valid, match_valid}, 9'h100);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(in_ready == 1'b1 && qry_en == '0 && !ana_req_valid && !match_valid,
          "R9 state after reset", {in_ready, qry_en, ana_req_valid, match_valid}, 9'h100);
      @(negedge clk);

      // R10: stray answer while scanning
      ana_rsp_valid = 1'b1; ana_rsp_hit = 1'b1;
      @(posedge clk); @(negedge clk);
      ana_rsp_valid = 1'b0;
      @(posedge clk); @(negedge clk); #1;
      chk(match_valid == 1'b0 && in_ready == 1'b1, "R10 stray response ignored", match_valid, 0);
      @(negedge clk);

      // R1: back-to-back burst, filters quiet
      flt_mode = 0;
      for (int i = 0; i < 12; i++) begin
         logic [7:0] b;
         b = 8'(8'h30 + i);
         in_valid = 1'b1; in_data = b; in_last = (i == 11);
         #1 chk(in_ready == 1'b1, "R1 burst ready", in_ready, 1);
         if (i > 0) chk(win_data == m_win, "R1 burst lanes", win_data, m_win);
         @(posedge clk); @(negedge clk);
         model_push(b, i == 11);
      end
      in_valid = 1'b0; in_last = 1'b0;
      #1 chk(win_data == m_win, "R1 burst final lanes", win_data, m_win);
      @(negedge clk);

      // R8: short packet then new packet, every length hits, accept all
      flt_mode = 2; conf_mode = 2;
      feed(8'h11, 1'b0);
      feed(8'h22, 1'b1);
      feed(8'h33, 1'b0);
      chk(win_data[LMAX*8-1:8] == '0, "R8 older lanes flushed", win_data[LMAX*8-1:8], 0);
      feed(8'h44, 1'b0);
      feed(8'h55, 1'b0);
      chk(m_pos == 2, "R8 offset restart", m_pos, 2);
      for (int i = 0; i < 6; i++) feed(8'(8'h60 + i), 1'b0);

      // R7: every length hits, analyzer rejects all
      conf_mode = 1;
      feed(8'h7a, 1'b0);
      feed(8'h7b, 1'b1);

      // R3/R5/R6: hashed filters and analyzer, random packets
      flt_mode = 1; conf_mode = 0;
      for (int p = 0; p < 8; p++) begin
         int len;
         len = 1 + int'($urandom % 20);
         for (int j = 0; j < len; j++) feed(8'($urandom), j == len - 1);
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule